// File: doc/BRIEF.md
# Dual Cascadable Interval Timer

This block holds two 8-bit up-counting interval timers that share one mode register. Each timer steps from a source chosen in the mode register: a divide-by-12 or divide-by-384 prescaler of the system clock, or rising edges of an external input pin. The second timer has one more option: it can step once on every compare match of the first timer, which turns the pair into a single long timer. When a counter steps to its compare value, it returns to zero and raises its own interrupt flag. The flag stays up until the matching clear input pulls it down.

A single wave output flip-flop toggles on the matches of whichever timer the mode register selects. A third selection freezes it. Software-facing decode and interrupt routing live outside the block. Mode and compare values arrive through plain write-enable ports. Each write takes effect from the clock cycle after the edge that captures it. All ports are plain control pins, so there is no handshake and no back-pressure.

Top module: `twin_interval_timer`

## Requirements
- R1: A synchronous reset clears the mode register, both compare registers, both prescalers, both counters, both flags and the wave output to zero.
- R2: With mode bits 3:2 = 00, timer 0 steps once per 12 system clocks.
- R3: With mode bits 3:2 = 01, timer 0 steps once per 384 system clocks.
- R4: With mode bits 3:2 = 10, timer 0 steps once per rising edge of ext_in. The pin passes through a two-flop synchronizer and an edge register. A rise sampled at clock edge k steps the counter at edge k+2.
- R5: With mode bits 3:2 = 11, timer 0 is stopped: its count does not change and it never matches.
- R6: While mode bit 4 is set, timer 0 is held at zero, and neither it nor its prescaler advances.
- R7: Timer 1 picks its source with mode bits 6:5, using the same codes: 00 divides by 12, 01 divides by 384, 10 uses the rising edges of ext_in. Each timer has its own prescaler.
- R8: With mode bits 7:5 = 011, timer 1 steps exactly once for each timer 0 match, on the same clock edge as that match.
- R9: While mode bit 7 is set, timer 1 is held at zero.
- R10: When a step makes a counter equal its compare register, the counter becomes zero and the timer's flag sets on that same edge. A compare value of 0 gives a match every 256 steps.
- R11: A flag stays set until its clear input is high at a clock edge. If a match and a clear arrive at the same edge, the flag is left set.
- R12: Mode bits 1:0 choose what toggles wave_out: 00 toggles it on timer 0 matches, 01 toggles it on timer 1 matches, and 10 or 11 leave it unchanged.
- R13: Each prescaler keeps its residue. Rewriting the mode register does not restart a prescaler's phase. After a switch to a smaller divisor, a leftover count at or above the new divisor yields one step per clock until it falls below the new divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 8 | New mode value |
| cmp0_we | input | 1 | Write strobe for timer 0 compare |
| cmp0_wdata | input | CNT_W | New timer 0 compare value |
| cmp1_we | input | 1 | Write strobe for timer 1 compare |
| cmp1_wdata | input | CNT_W | New timer 1 compare value |
| ext_in | input | 1 | Asynchronous external count pin |
| t0_flag_clr | input | 1 | Clears the timer 0 flag |
| t1_flag_clr | input | 1 | Clears the timer 1 flag |
| t0_flag | output | 1 | Timer 0 interrupt request flag |
| t1_flag | output | 1 | Timer 1 interrupt request flag |
| wave_out | output | 1 | Toggle flip-flop output |

## Verification
Each source selection is driven in turn with the timers set to small compare values:
- The divide-by-12 and divide-by-384 runs tell the two divisors apart by their match rate.
- A run that rewrites the mode register every few clocks shows that the prescaler phase is kept, since a restarting prescaler would never reach a match.
- A train of exactly fifteen pin pulses gives exact match counts for both timers, which separates edge counting from level counting.
- The chained run gives exactly one timer 1 step per timer 0 match.
- The held and stopped settings must produce no match at all.
- A compare value of zero must produce exactly two matches in just over 512 divided steps.
- A clear input held high throughout must still let every match raise the flag.

// File: rtl/ivt_pkg.sv
`timescale 1ns/1ps
package ivt_pkg;

  typedef enum logic [1:0] {
    SRC_FAST = 2'b00,
    SRC_SLOW = 2'b01,
    SRC_PIN  = 2'b10,
    SRC_ALT  = 2'b11
  } ivt_src_e;

  typedef enum logic [1:0] {
    WAVE_T0    = 2'b00,
    WAVE_T1    = 2'b01,
    WAVE_FRZ_A = 2'b10,
    WAVE_FRZ_B = 2'b11
  } ivt_wave_e;

  // bit 7: timer 1 hold, 6:5 timer 1 source, 4: timer 0 hold,
  // 3:2 timer 0 source, 1:0 wave source
  typedef struct packed {
    logic      t1_hold;
    ivt_src_e  t1_src;
    logic      t0_hold;
    ivt_src_e  t0_src;
    ivt_wave_e wave_src;
  } ivt_mode_t;

  function automatic logic uses_divider(ivt_src_e s);
    return (s == SRC_FAST) || (s == SRC_SLOW);
  endfunction

  function automatic logic pick_step(ivt_src_e s, logic pre, logic pin, logic alt);
    logic r;
    case (s)
      SRC_FAST, SRC_SLOW: r = pre;
      SRC_PIN:            r = pin;
      default:            r = alt;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ivt_prescale.sv
`timescale 1ns/1ps
module ivt_prescale #(
  parameter int DIV_FAST = 12,
  parameter int DIV_SLOW = 384
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic slow,
  output logic tick
);
  localparam int ACC_W = $clog2(DIV_SLOW) + 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_inc;
  logic [ACC_W-1:0] divisor;

  always_comb begin
    acc_inc = acc_q + 1'b1;
    divisor = slow ? ACC_W'(DIV_SLOW) : ACC_W'(DIV_FAST);
    tick    = run && (acc_inc >= divisor);
  end

  // residue is kept: on a tick only the divisor is removed
  always_ff @(posedge clk) begin
    if (rst)
      acc_q <= '0;
    else if (run)
      acc_q <= tick ? (acc_inc - divisor) : acc_inc;
  end
endmodule

// File: rtl/ivt_edge_sync.sv
`timescale 1ns/1ps
module ivt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/ivt_count_unit.sv
`timescale 1ns/1ps
module ivt_count_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         match,
  output logic [W-1:0] value
);
  logic [W-1:0] value_q;
  logic [W-1:0] nxt;

  always_comb begin
    nxt   = value_q + 1'b1;
    match = step && !hold && (nxt == limit);
  end

  always_ff @(posedge clk) begin
    if (rst || hold)
      value_q <= '0;
    else if (step)
      value_q <= match ? '0 : nxt;
  end

  assign value = value_q;
endmodule

// File: rtl/twin_interval_timer.sv
`timescale 1ns/1ps
module twin_interval_timer
  import ivt_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int DIV_FAST    = 12,
  parameter int DIV_SLOW    = 384,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_we,
  input  logic [7:0]       mode_wdata,
  input  logic             cmp0_we,
  input  logic [CNT_W-1:0] cmp0_wdata,
  input  logic             cmp1_we,
  input  logic [CNT_W-1:0] cmp1_wdata,
  input  logic             ext_in,
  input  logic             t0_flag_clr,
  input  logic             t1_flag_clr,
  output logic             t0_flag,
  output logic             t1_flag,
  output logic             wave_out
);
  localparam int NUM_TMR = 2;

  ivt_mode_t          mode_q;
  logic [CNT_W-1:0]   cmp0_q;
  logic [CNT_W-1:0]   cmp1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      cmp0_q <= '0;
      cmp1_q <= '0;
    end else begin
      if (mode_we) mode_q <= ivt_mode_t'(mode_wdata);
      if (cmp0_we) cmp0_q <= cmp0_wdata;
      if (cmp1_we) cmp1_q <= cmp1_wdata;
    end
  end

  logic pin_rise;

  ivt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .pin  (ext_in),
    .rise (pin_rise)
  );

  // per-timer prescaler control
  logic [NUM_TMR-1:0] hold;
  logic [NUM_TMR-1:0] pre_run;
  logic [NUM_TMR-1:0] pre_slow;
  logic [NUM_TMR-1:0] pre_tick;

  always_comb begin
    hold[0]     = mode_q.t0_hold;
    hold[1]     = mode_q.t1_hold;
    pre_run[0]  = !hold[0] && uses_divider(mode_q.t0_src);
    pre_run[1]  = !hold[1] && uses_divider(mode_q.t1_src);
    pre_slow[0] = (mode_q.t0_src == SRC_SLOW);
    pre_slow[1] = (mode_q.t1_src == SRC_SLOW);
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_pre
    ivt_prescale #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_pre (
      .clk  (clk),
      .rst  (rst),
      .run  (pre_run[i]),
      .slow (pre_slow[i]),
      .tick (pre_tick[i])
    );
  end

  // timer 0: the alternate code means stopped
  logic             t0_step;
  logic             t0_hit;
  logic [CNT_W-1:0] t0_value;

  assign t0_step = pick_step(mode_q.t0_src, pre_tick[0], pin_rise, 1'b0);

  ivt_count_unit #(.W(CNT_W)) u_cnt0 (
    .clk   (clk),
    .rst   (rst),
    .hold  (hold[0]),
    .step  (t0_step),
    .limit (cmp0_q),
    .match (t0_hit),
    .value (t0_value)
  );

  // timer 1: the alternate code chains it to timer 0 matches
  logic             t1_step;
  logic             t1_hit;
  logic [CNT_W-1:0] t1_value;

  assign t1_step = pick_step(mode_q.t1_src, pre_tick[1], pin_rise, t0_hit);

  ivt_count_unit #(.W(CNT_W)) u_cnt1 (
    .clk   (clk),
    .rst   (rst),
    .hold  (hold[1]),
    .step  (t1_step),
    .limit (cmp1_q),
    .match (t1_hit),
    .value (t1_value)
  );

  // request flags: a new match wins over a clear
  logic [NUM_TMR-1:0] hit;
  logic [NUM_TMR-1:0] clr;
  logic [NUM_TMR-1:0] flag_q;

  assign hit = {t1_hit, t0_hit};
  assign clr = {t1_flag_clr, t0_flag_clr};

  always_ff @(posedge clk) begin
    if (rst)
      flag_q <= '0;
    else
      flag_q <= hit | (flag_q & ~clr);
  end

  // wave output toggle
  logic wave_q;

  always_ff @(posedge clk) begin
    if (rst)
      wave_q <= 1'b0;
    else begin
      case (mode_q.wave_src)
        WAVE_T0: if (hit[0]) wave_q <= ~wave_q;
        WAVE_T1: if (hit[1]) wave_q <= ~wave_q;
        default: ;
      endcase
    end
  end

  assign t0_flag  = flag_q[0];
  assign t1_flag  = flag_q[1];
  assign wave_out = wave_q;
endmodule

// File: rtl/ivt_checker.sv
`timescale 1ns/1ps
module ivt_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [7:0]   mode,
  input logic [W-1:0] cnt0,
  input logic [W-1:0] cnt1,
  input logic         hit0,
  input logic         hit1,
  input logic         irq0,
  input logic         irq1,
  input logic         clr0,
  input logic         clr1,
  input logic         tout
);
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (!irq0 && !irq1 && !tout && cnt0 == '0 && cnt1 == '0));

  a_r5_stopped_frozen: assert property (@(posedge clk) disable iff (rst)
    (mode[3:2] == 2'b11 && !mode[4]) |=> $stable(cnt0));

  a_r6_hold_zero: assert property (@(posedge clk) disable iff (rst)
    mode[4] |=> (cnt0 == '0));

  a_r8_chain_only_on_match: assert property (@(posedge clk) disable iff (rst)
    (mode[7:5] == 3'b011 && !hit0) |=> $stable(cnt1));

  a_r9_hold_zero: assert property (@(posedge clk) disable iff (rst)
    mode[7] |=> (cnt1 == '0));

  a_r10_match_clears0: assert property (@(posedge clk) disable iff (rst)
    hit0 |=> (cnt0 == '0));

  a_r10_match_clears1: assert property (@(posedge clk) disable iff (rst)
    hit1 |=> (cnt1 == '0));

  a_r11_set_wins0: assert property (@(posedge clk) disable iff (rst)
    hit0 |=> irq0);

  a_r11_set_wins1: assert property (@(posedge clk) disable iff (rst)
    hit1 |=> irq1);

  a_r11_sticky0: assert property (@(posedge clk) disable iff (rst)
    (irq0 && !clr0) |=> irq0);

  a_r11_sticky1: assert property (@(posedge clk) disable iff (rst)
    (irq1 && !clr1) |=> irq1);

  a_r12_wave_frozen: assert property (@(posedge clk) disable iff (rst)
    mode[1] |=> $stable(tout));
endmodule

bind twin_interval_timer ivt_checker #(.W(CNT_W)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .mode (mode_q),
  .cnt0 (t0_value),
  .cnt1 (t1_value),
  .hit0 (t0_hit),
  .hit1 (t1_hit),
  .irq0 (t0_flag),
  .irq1 (t1_flag),
  .clr0 (t0_flag_clr),
  .clr1 (t1_flag_clr),
  .tout (wave_out)
);

// File: tb/sim_twin_interval_timer.sv
`timescale 1ns/1ps
module sim_twin_interval_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_we = 1'b0;
  logic [7:0] mode_wdata = '0;
  logic       cmp0_we = 1'b0;
  logic [7:0] cmp0_wdata = '0;
  logic       cmp1_we = 1'b0;
  logic [7:0] cmp1_wdata = '0;
  logic       ext_in = 1'b0;
  logic       t0_flag_clr = 1'b0;
  logic       t1_flag_clr = 1'b0;
  logic       t0_flag, t1_flag, wave_out;

  always #4 clk = ~clk;

  twin_interval_timer u0 (
    .clk(clk), .rst(rst),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .cmp0_we(cmp0_we), .cmp0_wdata(cmp0_wdata),
    .cmp1_we(cmp1_we), .cmp1_wdata(cmp1_wdata),
    .ext_in(ext_in),
    .t0_flag_clr(t0_flag_clr), .t1_flag_clr(t1_flag_clr),
    .t0_flag(t0_flag), .t1_flag(t1_flag), .wave_out(wave_out)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string cur_req = "R1";
  bit    auto_clr = 0;
  bit    frc0 = 0;
  bit    frc1 = 0;
  int    ev0 = 0, ev1 = 0, evw = 0;
  logic  p0 = 0, p1 = 0, pw = 0;

  // behavioural reference state
  int m_mode, m_c0, m_c1, r_cnt0, r_cnt1, r_acc0, r_acc1;
  int s1, s2, sprev, f0, f1, fw;

  always @(posedge clk) begin : model
    int sel, d, rise, step0, step1, m0, m1;
    if (rst) begin
      m_mode = 0; m_c0 = 0; m_c1 = 0; r_cnt0 = 0; r_cnt1 = 0;
      r_acc0 = 0; r_acc1 = 0; s1 = 0; s2 = 0; sprev = 0;
      f0 = 0; f1 = 0; fw = 0;
    end else begin
      rise = (s2 == 1 && sprev == 0) ? 1 : 0;
      step0 = 0; m0 = 0; step1 = 0; m1 = 0;
      if (m_mode & 16) r_cnt0 = 0;
      else begin
        sel = (m_mode >> 2) & 3;
        if (sel < 2) begin
          d = (sel == 1) ? 384 : 12;
          r_acc0 = r_acc0 + 1;
          if (r_acc0 >= d) begin r_acc0 = r_acc0 - d; step0 = 1; end
        end else if (sel == 2) step0 = rise;
        if (step0 == 1) begin
          r_cnt0 = (r_cnt0 + 1) % 256;
          if (r_cnt0 == m_c0) begin r_cnt0 = 0; m0 = 1; end
        end
      end
      if (m_mode & 128) r_cnt1 = 0;
      else begin
        sel = (m_mode >> 5) & 3;
        if (sel < 2) begin
          d = (sel == 1) ? 384 : 12;
          r_acc1 = r_acc1 + 1;
          if (r_acc1 >= d) begin r_acc1 = r_acc1 - d; step1 = 1; end
        end else if (sel == 2) step1 = rise;
        else step1 = m0;
        if (step1 == 1) begin
          r_cnt1 = (r_cnt1 + 1) % 256;
          if (r_cnt1 == m_c1) begin r_cnt1 = 0; m1 = 1; end
        end
      end
      f0 = (m0 == 1) ? 1 : (t0_flag_clr ? 0 : f0);
      f1 = (m1 == 1) ? 1 : (t1_flag_clr ? 0 : f1);
      if ((m_mode & 3) == 0 && m0 == 1) fw = 1 - fw;
      if ((m_mode & 3) == 1 && m1 == 1) fw = 1 - fw;
      sprev = s2; s2 = s1; s1 = ext_in ? 1 : 0;
      if (mode_we) m_mode = int'(mode_wdata);
      if (cmp0_we) m_c0 = int'(cmp0_wdata);
      if (cmp1_we) m_c1 = int'(cmp1_wdata);
    end
    #2;
    if (!rst && !done) begin
      checks++;
      if (t0_flag !== (f0 == 1) || t1_flag !== (f1 == 1) || wave_out !== (fw == 1)) begin
        errors++;
        $display("FAIL %s per-cycle t0/t1/wave actual=%b%b%b expected=%0d%0d%0d",
                 cur_req, t0_flag, t1_flag, wave_out, f0, f1, fw);
      end
      if (t0_flag && !p0) ev0++;
      if (t1_flag && !p1) ev1++;
      if (wave_out !== pw) evw++;
      p0 = t0_flag; p1 = t1_flag; pw = wave_out;
    end
  end

  task automatic drive_idle();
    t0_flag_clr = frc0 | (auto_clr & t0_flag);
    t1_flag_clr = frc1 | (auto_clr & t1_flag);
    mode_we = 0; cmp0_we = 0; cmp1_we = 0;
  endtask

  task automatic run(int n);
    repeat (n) begin @(negedge clk); drive_idle(); end
  endtask

  task automatic wr_mode(logic [7:0] v);
    @(negedge clk); drive_idle(); mode_we = 1; mode_wdata = v;
  endtask

  task automatic wr_cmp(logic [7:0] a, logic [7:0] b);
    @(negedge clk); drive_idle();
    cmp0_we = 1; cmp0_wdata = a; cmp1_we = 1; cmp1_wdata = b;
  endtask

  task automatic restart(logic [7:0] v);
    wr_mode(8'h90);
    wr_mode(v);
    run(2);
    ev0 = 0; ev1 = 0; evw = 0;
  endtask

  task automatic pulse_pin(int n);
    repeat (n) begin
      @(negedge clk); drive_idle(); ext_in = 1;
      run(1);
      @(negedge clk); drive_idle(); ext_in = 0;
      run(1);
    end
  endtask

  task automatic expect_in(string req, string what, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin : stim
    run(5);
    cur_req = "R1";
    expect_in("R1", "t0_flag in reset", int'(t0_flag), 0, 0);
    expect_in("R1", "t1_flag in reset", int'(t1_flag), 0, 0);
    expect_in("R1", "wave_out in reset", int'(wave_out), 0, 0);
    @(negedge clk); rst = 0;
    run(3);
    expect_in("R1", "t0_flag after reset", int'(t0_flag), 0, 0);

    // R2 / R7 / R12: fast dividers, wave from timer 0
    cur_req = "R2";
    auto_clr = 1;
    wr_cmp(8'd4, 8'd3);
    restart(8'h00);
    run(480);
    expect_in("R2", "timer0 /12 matches", ev0, 9, 11);
    expect_in("R7", "timer1 /12 matches", ev1, 12, 14);
    expect_in("R12", "wave toggles vs t0 matches", evw, ev0, ev0);

    // R13: mode rewrites keep prescaler phase
    cur_req = "R13";
    ev0 = 0; ev1 = 0; evw = 0;
    for (int k = 0; k < 96; k++) begin
      wr_mode(8'h00);
      run(4);
    end
    expect_in("R13", "timer0 matches under rewrites", ev0, 9, 11);

    // R3 / R7: slow dividers, wave from timer 1
    cur_req = "R3";
    wr_cmp(8'd2, 8'd1);
    restart(8'h25);
    run(3072);
    expect_in("R3", "timer0 /384 matches", ev0, 3, 5);
    expect_in("R7", "timer1 /384 matches", ev1, 7, 9);
    expect_in("R12", "wave toggles vs t1 matches", evw, ev1, ev1);

    // R4 / R7: pin source, wave frozen
    cur_req = "R4";
    wr_cmp(8'd3, 8'd5);
    restart(8'h4A);
    pulse_pin(15);
    run(6);
    expect_in("R4", "timer0 pin matches", ev0, 5, 5);
    expect_in("R7", "timer1 pin matches", ev1, 3, 3);
    expect_in("R12", "wave frozen toggles", evw, 0, 0);

    // R5: timer0 stopped, timer1 chained to it
    cur_req = "R5";
    wr_cmp(8'd1, 8'd1);
    restart(8'h6C);
    pulse_pin(5);
    run(600);
    expect_in("R5", "stopped timer0 matches", ev0, 0, 0);
    expect_in("R5", "chained timer1 matches", ev1, 0, 0);

    // R6: timer0 held, timer1 fast
    cur_req = "R6";
    wr_cmp(8'd1, 8'd3);
    wr_mode(8'h10);
    run(2);
    ev0 = 0; ev1 = 0; evw = 0;
    run(600);
    expect_in("R6", "held timer0 matches", ev0, 0, 0);
    expect_in("R6", "timer1 still runs", ev1, 15, 18);
    expect_in("R6", "wave toggles", evw, 0, 0);

    // R9: timer1 held, timer0 fast
    cur_req = "R9";
    restart(8'h80);
    run(600);
    expect_in("R9", "held timer1 matches", ev1, 0, 0);
    expect_in("R9", "timer0 still runs", ev0, 48, 51);

    // R8: chained pair
    cur_req = "R8";
    wr_cmp(8'd3, 8'd2);
    restart(8'h61);
    run(720);
    expect_in("R8", "timer0 matches", ev0, 19, 21);
    expect_in("R8", "timer1 = half of timer0", ev1, ev0 / 2, ev0 / 2);
    expect_in("R12", "wave toggles vs t1 matches", evw, ev1, ev1);

    // R10: compare zero means 256 steps
    cur_req = "R10";
    wr_cmp(8'd0, 8'd7);
    restart(8'h02);
    run(6200);
    expect_in("R10", "compare 0 matches", ev0, 2, 2);

    // R11: sticky flag and set-beats-clear
    cur_req = "R11";
    wr_cmp(8'd2, 8'd7);
    restart(8'h02);
    auto_clr = 0;
    run(100);
    expect_in("R11", "sticky t0_flag", int'(t0_flag), 1, 1);
    expect_in("R11", "single rise without clear", ev0, 1, 1);
    frc0 = 1;
    run(2);
    ev0 = 0;
    run(240);
    expect_in("R11", "rises under constant clear", ev0, 9, 10);
    frc0 = 0;
    run(4);
    finish_run();
  end
endmodule